// File: doc/BRIEF.md
# Pixel clip-rectangle and scissor visibility test

This block sits in a rasterizer back end, just before pixels are written. It decides, one pixel per cycle, whether a pixel may be written. It holds four clip rectangles, a 16-bit combination word and one scissor rectangle. Software loads them through a flat register write port.

For every valid pixel coordinate, the block first adds the fixed clipping origin of 1440 to both X and Y. It then builds a 4-bit membership code whose bit i is set when the pixel lies inside rectangle i. That code indexes the combination word, so any boolean function of the four rectangles can be chosen. The chosen bit is then ANDed with a scissor test. The result appears one cycle later as a pass flag, together with the original coordinate.

Top module: `pixel_vis_test`

## Requirements
- R1: Rectangle i contains a pixel when the biased X lies between its top-left X and bottom-right X, and the biased Y lies between its top-left Y and bottom-right Y. All four bounds are inclusive. Bit i of the membership code (i = 0..3) is set exactly when rectangle i contains the pixel.
- R2: The clip stage passes a pixel only when bit `code` of the 16-bit combination word is 1. Bit 0 applies to pixels outside every rectangle, and bit 15 to pixels inside all four.
- R3: A pixel passes only if, in addition, it lies inside the scissor rectangle, whose corners are also inclusive.
- R4: Before any comparison, 1440 is added to the incoming X and Y. The sums wrap modulo 8192 and are compared as 13-bit unsigned values. Framebuffer pixel (0,0) therefore tests as (1440,1440), and pixel X = 6752 tests as 0.
- R5: A write with `cfg_we`=1 loads one register selected by `cfg_idx`:
  - 2i: top-left corner of rectangle i.
  - 2i+1: bottom-right corner of rectangle i.
  - 8: combination word, taken from data bits 15:0.
  - 9: scissor top-left corner.
  - 10: scissor bottom-right corner.
  Corner data carries X in bits 12:0 and Y in bits 25:13. All other data bits are ignored. Indices 11 to 15 change nothing.
- R6: After reset, every rectangle and the scissor span 0..8191 in both axes, the combination word is 0xFFFF, and `out_valid` is 0. Every pixel therefore passes.
- R7: Results are registered and appear one cycle after the input. `out_valid` equals the previous cycle's `px_valid`, `out_x` and `out_y` equal the previous cycle's input coordinate, and `out_pass` is 0 whenever `out_valid` is 0.
- R8: A register write takes effect for pixels presented in the cycle after the write. A pixel presented in the same cycle as a write is tested against the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 4 | Register index |
| cfg_wdata | input | 32 | Register write data |
| px_valid | input | 1 | Pixel coordinate valid |
| px_x | input | 13 | Framebuffer-relative pixel X |
| px_y | input | 13 | Framebuffer-relative pixel Y |
| out_valid | output | 1 | Result valid, one cycle after `px_valid` |
| out_x | output | 13 | Pixel X passed through |
| out_y | output | 13 | Pixel Y passed through |
| out_pass | output | 1 | 1 = write the pixel, 0 = kill it |

## Verification
Each pixel result is due exactly one clock edge after the pixel is presented. The bench drives each pixel on a falling edge, drops `px_valid` on the next falling edge, and reads the outputs at that moment, which lies one rising edge later. A configuration write drives `cfg_we` for one falling-to-falling interval, so it takes effect for the next pixel. The one case where a write and a pixel share a cycle is checked against the old settings, and then again one cycle later against the new ones. Expected pass values come from a bench model that recomputes the biased coordinates, the membership code and the lookup with integer arithmetic.

// File: rtl/pixel_vis_pkg.sv
package pixel_vis_pkg;
  localparam int COORD_W  = 13;
  localparam int NUM_RECT = 4;
  localparam int CTRL_W   = 1 << NUM_RECT;
  localparam int ORIGIN   = 1440;
  localparam int IDX_W    = 4;
  localparam int DATA_W   = 32;

  localparam int IDX_CTRL    = 2 * NUM_RECT;
  localparam int IDX_SCIS_TL = IDX_CTRL + 1;
  localparam int IDX_SCIS_BR = IDX_CTRL + 2;

  typedef logic [COORD_W-1:0] coord_t;

  // y sits above x so that a packed corner matches write-data bits 25:0
  typedef struct packed {
    coord_t y;
    coord_t x;
  } corner_t;

  typedef struct packed {
    corner_t br;
    corner_t tl;
  } rect_t;

  localparam rect_t FULL_RECT = {{(2*COORD_W){1'b1}}, {(2*COORD_W){1'b0}}};

  // add the clipping origin, wrapping in COORD_W bits
  function automatic coord_t bias_coord(input coord_t c);
    return c + COORD_W'(ORIGIN);
  endfunction

  // inclusive containment test on both axes
  function automatic logic in_rect(input corner_t p, input rect_t r);
    return (p.x >= r.tl.x) && (p.x <= r.br.x) &&
           (p.y >= r.tl.y) && (p.y <= r.br.y);
  endfunction

  function automatic corner_t unpack_corner(input logic [DATA_W-1:0] d);
    return corner_t'(d[2*COORD_W-1:0]);
  endfunction
endpackage

// File: rtl/pixel_vis_regs.sv
module pixel_vis_regs
  import pixel_vis_pkg::*;
#(
  parameter int N = NUM_RECT
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [IDX_W-1:0]      idx,
  input  logic [DATA_W-1:0]     wdata,
  output rect_t [N-1:0]         clip_q,
  output logic  [CTRL_W-1:0]    ctrl_q,
  output rect_t                 scis_q
);
  logic unused_hi;
  assign unused_hi = ^wdata[DATA_W-1:2*COORD_W];

  corner_t wcorner;
  assign wcorner = unpack_corner(wdata);

  for (genvar g = 0; g < N; g++) begin : g_rect
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        clip_q[g] <= FULL_RECT;
      end else if (we && idx == IDX_W'(2*g)) begin
        clip_q[g].tl <= wcorner;
      end else if (we && idx == IDX_W'(2*g+1)) begin
        clip_q[g].br <= wcorner;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '1;
      scis_q <= FULL_RECT;
    end else if (we) begin
      if (idx == IDX_W'(IDX_CTRL))    ctrl_q    <= wdata[CTRL_W-1:0];
      if (idx == IDX_W'(IDX_SCIS_TL)) scis_q.tl <= wcorner;
      if (idx == IDX_W'(IDX_SCIS_BR)) scis_q.br <= wcorner;
    end
  end
endmodule

// File: rtl/pixel_vis_rect.sv
module pixel_vis_rect
  import pixel_vis_pkg::*;
(
  input  corner_t pt,
  input  rect_t   r,
  output logic    hit
);
  assign hit = in_rect(pt, r);
endmodule

// File: rtl/pixel_vis_test.sv
module pixel_vis_test
  import pixel_vis_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic [DATA_W-1:0]   cfg_wdata,
  input  logic                px_valid,
  input  logic [COORD_W-1:0]  px_x,
  input  logic [COORD_W-1:0]  px_y,
  output logic                out_valid,
  output logic [COORD_W-1:0]  out_x,
  output logic [COORD_W-1:0]  out_y,
  output logic                out_pass
);
  rect_t [NUM_RECT-1:0] clip_q;
  logic  [CTRL_W-1:0]   ctrl_q;
  rect_t                scis_q;

  pixel_vis_regs #(.N(NUM_RECT)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .idx    (cfg_idx),
    .wdata  (cfg_wdata),
    .clip_q (clip_q),
    .ctrl_q (ctrl_q),
    .scis_q (scis_q)
  );

  // biased test point
  corner_t pt;
  assign pt.x = bias_coord(px_x);
  assign pt.y = bias_coord(px_y);

  // membership code, one comparator per rectangle
  logic [NUM_RECT-1:0] mem_code;
  for (genvar g = 0; g < NUM_RECT; g++) begin : g_hit
    pixel_vis_rect u_cmp (
      .pt  (pt),
      .r   (clip_q[g]),
      .hit (mem_code[g])
    );
  end

  logic scis_hit;
  pixel_vis_rect u_scis (
    .pt  (pt),
    .r   (scis_q),
    .hit (scis_hit)
  );

  // named events for the checker
  logic clip_hit;
  logic pass_d;
  assign clip_hit = ctrl_q[mem_code];
  assign pass_d   = px_valid && clip_hit && scis_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pass  <= 1'b0;
      out_x     <= '0;
      out_y     <= '0;
    end else begin
      out_valid <= px_valid;
      out_pass  <= pass_d;
      if (px_valid) begin
        out_x <= px_x;
        out_y <= px_y;
      end
    end
  end
endmodule

// File: rtl/pixel_vis_test_chk.sv
module pixel_vis_test_chk
  import pixel_vis_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               px_valid,
  input logic [COORD_W-1:0] px_x,
  input logic [COORD_W-1:0] px_y,
  input logic               out_valid,
  input logic [COORD_W-1:0] out_x,
  input logic [COORD_W-1:0] out_y,
  input logic               out_pass,
  input logic               clip_hit,
  input logic               scis_hit
);
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(px_valid));

  a_r7_coord_through: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid |=> (out_x == $past(px_x)) && (out_y == $past(px_y)));

  a_r7_idle_no_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_pass);

  a_r3_scissor_kills: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && !scis_hit) |=> !out_pass);

  a_r2_clip_kills: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && !clip_hit) |=> !out_pass);

  a_r2_both_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && clip_hit && scis_hit) |=> out_pass);
endmodule

bind pixel_vis_test pixel_vis_test_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .px_valid  (px_valid),
  .px_x      (px_x),
  .px_y      (px_y),
  .out_valid (out_valid),
  .out_x     (out_x),
  .out_y     (out_y),
  .out_pass  (out_pass),
  .clip_hit  (clip_hit),
  .scis_hit  (scis_hit)
);

// File: tb/pixel_vis_test_test.sv
module pixel_vis_test_test;
  localparam int CLK_PERIOD = 10;
  localparam int OFS = 1440;
  localparam int MAXC = 8191;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        px_valid = 1'b0;
  logic [12:0] px_x = '0;
  logic [12:0] px_y = '0;
  logic        out_valid;
  logic [12:0] out_x;
  logic [12:0] out_y;
  logic        out_pass;

  int n_checks = 0;
  int n_fails = 0;
  bit done = 0;

  // shadow of the programmed state, in biased units
  int tlx[4], tly[4], brx[4], bry[4];
  int stlx, stly, sbrx, sbry;
  int ctrl;

  pixel_vis_test uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .px_valid(px_valid), .px_x(px_x), .px_y(px_y),
    .out_valid(out_valid), .out_x(out_x), .out_y(out_y), .out_pass(out_pass)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit model(input int x, input int y);
    int bx, by, code;
    bit sc;
    bx = (x + OFS) % 8192;
    by = (y + OFS) % 8192;
    code = 0;
    for (int i = 0; i < 4; i++)
      if (bx >= tlx[i] && bx <= brx[i] && by >= tly[i] && by <= bry[i])
        code += (1 << i);
    sc = (bx >= stlx && bx <= sbrx && by >= stly && by <= sbry);
    return ((ctrl >> code) & 1) == 1 && sc;
  endfunction

  function automatic logic [31:0] pack(input int x, input int y);
    return (32'(y & MAXC) << 13) | 32'(x & MAXC);
  endfunction

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // corners given framebuffer-relative; stored biased
  task automatic set_rect(input int i, input int x0, input int y0, input int x1, input int y1);
    tlx[i] = x0 + OFS; tly[i] = y0 + OFS; brx[i] = x1 + OFS; bry[i] = y1 + OFS;
    wr(2*i, pack(tlx[i], tly[i]));
    wr(2*i+1, pack(brx[i], bry[i]));
  endtask

  task automatic set_ctrl(input int c);
    ctrl = c & 16'hFFFF;
    wr(8, 32'(c));
  endtask

  task automatic set_scis_raw(input int x0, input int y0, input int x1, input int y1);
    stlx = x0; stly = y0; sbrx = x1; sbry = y1;
    wr(9, pack(x0, y0));
    wr(10, pack(x1, y1));
  endtask

  task automatic probe(input int x, input int y, input string tag);
    bit e;
    e = model(x, y);
    @(negedge clk);
    px_valid = 1'b1; px_x = 13'(x); px_y = 13'(y);
    @(negedge clk);
    px_valid = 1'b0;
    check(out_valid === 1'b1, {tag, " out_valid"}, int'(out_valid), 1);
    check(out_pass === e, {tag, " out_pass"}, int'(out_pass), int'(e));
    check(out_x === 13'(x) && out_y === 13'(y), {tag, " coord"},
          int'({out_y, out_x}), int'({13'(y), 13'(x)}));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      tlx[i] = 0; tly[i] = 0; brx[i] = MAXC; bry[i] = MAXC;
    end
    stlx = 0; stly = 0; sbrx = MAXC; sbry = MAXC; ctrl = 16'hFFFF;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6: reset state
    check(out_valid === 1'b0 && out_pass === 1'b0, "R6 reset outputs", int'(out_valid), 0);
    probe(0, 0, "R6 all pass");
    probe(8191, 8191, "R6 all pass");
    probe(1234, 77, "R6 all pass");

    // R7: idle cycle after a pixel
    @(negedge clk);
    check(out_valid === 1'b0 && out_pass === 1'b0, "R7 idle", int'(out_valid), 0);

    // R1: inclusive edges of rectangle 0
    set_rect(0, 10, 10, 20, 20);
    for (int i = 1; i < 4; i++) set_rect(i, 500, 500, 400, 400); // empty
    set_ctrl(16'h0002);
    probe(10, 10, "R1 tl"); probe(20, 20, "R1 br");
    probe(10, 20, "R1 bl"); probe(20, 10, "R1 tr");
    probe(9, 10, "R1 left");  probe(21, 10, "R1 right");
    probe(10, 9, "R1 above"); probe(10, 21, "R1 below");
    probe(15, 15, "R1 centre");

    // R1 / R2: overlap layout reaching all 16 codes, swept per lookup bit
    set_rect(0, 100, 100, 101, 103);
    set_rect(1, 101, 100, 102, 103);
    set_rect(2, 100, 100, 103, 101);
    set_rect(3, 100, 101, 103, 102);
    for (int k = 0; k < 16; k++) begin
      set_ctrl(1 << k);
      for (int y = 99; y <= 104; y++)
        for (int x = 99; x <= 104; x++)
          probe(x, y, "R2 code sweep");
    end
    set_ctrl(16'hA5C3);
    for (int y = 99; y <= 104; y++)
      for (int x = 99; x <= 104; x++)
        probe(x, y, "R2 mixed word");

    // R3: scissor edges with clip open
    set_ctrl(16'hFFFF);
    set_scis_raw(OFS + 50, OFS + 60, OFS + 70, OFS + 80);
    probe(50, 60, "R3 tl"); probe(70, 80, "R3 br");
    probe(49, 60, "R3 left"); probe(71, 80, "R3 right");
    probe(50, 59, "R3 above"); probe(70, 81, "R3 below");
    set_ctrl(16'h0001);
    probe(60, 70, "R3 with clip"); probe(100, 100, "R3 outside scissor");

    // R4: bias wraps at 8192
    set_ctrl(16'hFFFF);
    set_scis_raw(0, 0, 1439, MAXC);
    probe(6752, 5, "R4 wrap to 0"); probe(6751, 5, "R4 8191");
    probe(8191, 5, "R4 1439"); probe(0, 5, "R4 origin");

    // R5: reserved indices and bits ignored
    set_scis_raw(0, 0, MAXC, MAXC);
    for (int i = 11; i < 16; i++) wr(i, 32'h0000_0000);
    wr(8, 32'hFFFF_0001); ctrl = 16'h0001;
    probe(200, 200, "R5 ctrl high bits"); probe(100, 100, "R5 ctrl high bits");
    wr(10, 32'hFC00_0000 | pack(OFS + 300, OFS + 300)); sbrx = OFS + 300; sbry = OFS + 300;
    probe(300, 300, "R5 corner high bits"); probe(301, 300, "R5 corner high bits");
    for (int i = 11; i < 16; i++) wr(i, 32'hFFFF_FFFF);
    probe(300, 300, "R5 idx 11-15"); probe(400, 300, "R5 idx 11-15");

    // R8: same-cycle write uses old settings
    set_ctrl(16'hFFFF);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'd8; cfg_wdata = 32'h0;
    px_valid = 1'b1; px_x = 13'd250; px_y = 13'd250;
    @(negedge clk);
    cfg_we = 1'b0; px_valid = 1'b0;
    check(out_valid === 1'b1 && out_pass === 1'b1, "R8 old settings", int'(out_pass), 1);
    ctrl = 0;
    probe(250, 250, "R8 new settings");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule